// File: doc/BRIEF.md
# DMA Global and Channel Enable Controller

This block owns the master enable of a multi-channel DMA controller, the per-channel enable bits and the per-channel software transfer request bits for the source and destination sides. Software reaches it through a single-cycle register write port and a combinational read port, and the channel engines report back through per-channel busy and done lines and per-side request acknowledges. Its outputs are the channel enable vector the engines run on, the software request vectors they service, and the readback values.

Channel enable and request registers use a write-enable scheme. The upper half of the write word says which channel positions a write may touch, and the lower half carries the new values, so software never needs a read-modify-write. A channel enable bit drops by itself when its engine reports the end of its transfer. Clearing the master enable stops every channel at once, but the master bit keeps reading 1 until every engine has gone idle, so software can poll it to see when draining is over. Request bits take a write only for a channel that is enabled and whose side uses software handshaking. They clear when the engine acknowledges them.

Top module: `dmaen_ctrl`

## Requirements
- R1: After reset every channel enable, every request output and every readback value is 0.
- R2: A write with select 1 (channel enable) changes channel bit i to wr_data[i] only where wr_data[NCH+i] is 1. All other bits keep their value, and the change is visible one clock after the write.
- R3: While the software master enable is 0, every channel enable is 0 from the same edge that clears the master bit. Select-1 writes are ignored, and a select-1 read returns 0.
- R4: A pulse on ch_done[i] clears channel enable i at the next edge and leaves the other bits alone.
- R5: When ch_done[i] and a select-1 write setting bit i fall in the same cycle, bit i ends up 0.
- R6: Select 0 writes the master enable from wr_data[0] and reads it back in bit 0. If it is written 0 while any ch_busy bit is 1, it reads 1 until the first edge at which ch_busy is all 0, and 0 from then on.
- R7: A write with select 2 (source request) or 3 (destination request) changes request bit i only if wr_data[NCH+i] is 1 and channel i is enabled in that cycle.
- R8: A request bit on a side whose software handshake select (src_sw_sel or dst_sw_sel) is 0 ignores writes, and the request output and readback for it are 0.
- R9: An acknowledge on src_ack[i] or dst_ack[i] clears that request bit at the next edge, even when a write setting it falls in the same cycle.
- R10: A request bit is cleared at the edge after its channel enable reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 2 | Write target: 0 master, 1 channel enable, 2 source request, 3 destination request |
| wr_data | input | 2*NCH | Upper NCH bits are write enables, lower NCH bits are values |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | NCH | Combinational readback of the selected register |
| ch_busy | input | NCH | Channel engine still has activity in flight |
| ch_done | input | NCH | Channel engine finished its last destination transfer (pulse) |
| src_sw_sel | input | NCH | Source side of the channel uses software handshaking |
| dst_sw_sel | input | NCH | Destination side of the channel uses software handshaking |
| src_ack | input | NCH | Engine accepted the source software request |
| dst_ack | input | NCH | Engine accepted the destination software request |
| ch_en | output | NCH | Channel enable vector to the engines |
| src_req | output | NCH | Software source requests to the engines |
| dst_req | output | NCH | Software destination requests to the engines |

## Verification
The masked enable write is driven with all-enable, half-enable, no-enable and sparse-enable patterns. Together these separate a design that ignores the enable half of the word from one that swaps the halves or writes every position. Request writes go to a mix of enabled and disabled channels, which separates gating on the channel enable from gating on the write-enable bit alone. Directed cases collide a done pulse with a setting write, and an acknowledge with a setting write, to fix the priority. A busy channel holds the master bit while draining, which separates a drain-aware readback from a plain register.

// File: rtl/dmaen_pkg.sv
package dmaen_pkg;

  typedef enum logic [1:0] {
    SEL_MASTER = 2'd0,
    SEL_CHEN   = 2'd1,
    SEL_SREQ   = 2'd2,
    SEL_DREQ   = 2'd3
  } reg_sel_e;

  // Masked single-bit update: keep current value unless its enable is set.
  function automatic logic masked_bit(input logic cur, input logic we, input logic val);
    return we ? val : cur;
  endfunction

  // Next state of the drain flag for the master enable.
  function automatic logic drain_next(input logic wr, input logic val, input logic shown,
                                      input logic any_busy, input logic drain);
    if (wr) return !val && shown && any_busy;
    return drain && any_busy;
  endfunction

endpackage

// File: rtl/dmaen_master.sv
module dmaen_master
  import dmaen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_val,
  input  logic any_busy,
  output logic on_q,
  output logic on_next,
  output logic drain_q,
  output logic shown
);
  logic drain_d;

  assign on_next = wr_hit ? wr_val : on_q;
  assign shown   = on_q | drain_q;
  assign drain_d = drain_next(wr_hit, wr_val, shown, any_busy, drain_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b0;
      drain_q <= 1'b0;
    end else begin
      on_q    <= on_next;
      drain_q <= drain_d;
    end
  end
endmodule

// File: rtl/dmaen_en_cell.sv
module dmaen_en_cell
  import dmaen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic master_next,
  input  logic wr_hit,
  input  logic we,
  input  logic val,
  input  logic done,
  output logic en
);
  logic en_d;

  always_comb begin
    if (!master_next)  en_d = 1'b0;
    else if (done)     en_d = 1'b0;
    else if (wr_hit)   en_d = masked_bit(en, we, val);
    else               en_d = en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= 1'b0;
    else        en <= en_d;
  end
endmodule

// File: rtl/dmaen_req_bank.sv
module dmaen_req_bank
  import dmaen_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hit,
  input  logic [NCH-1:0] we,
  input  logic [NCH-1:0] val,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] sw_sel,
  input  logic [NCH-1:0] ack,
  output logic [NCH-1:0] req
);
  logic [NCH-1:0] req_q;

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    logic nxt;
    always_comb begin
      if (!ch_en[i])     nxt = 1'b0;
      else if (ack[i])   nxt = 1'b0;
      else if (wr_hit)   nxt = masked_bit(req_q[i], we[i] & sw_sel[i], val[i]);
      else               nxt = req_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q[i] <= 1'b0;
      else        req_q[i] <= nxt;
    end
  end

  assign req = req_q & sw_sel;
endmodule

// File: rtl/dmaen_ctrl.sv
module dmaen_ctrl
  import dmaen_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [2*NCH-1:0] wr_data,
  input  logic [1:0]       rd_sel,
  output logic [NCH-1:0]   rd_data,
  input  logic [NCH-1:0]   ch_busy,
  input  logic [NCH-1:0]   ch_done,
  input  logic [NCH-1:0]   src_sw_sel,
  input  logic [NCH-1:0]   dst_sw_sel,
  input  logic [NCH-1:0]   src_ack,
  input  logic [NCH-1:0]   dst_ack,
  output logic [NCH-1:0]   ch_en,
  output logic [NCH-1:0]   src_req,
  output logic [NCH-1:0]   dst_req
);
  localparam int WEB = NCH;

  logic [NCH-1:0] wr_we, wr_val;
  logic master_wr, chen_wr, sreq_wr, dreq_wr;
  logic master_on, master_next, master_drain, master_shown;
  logic [NCH-1:0] chen_we_eff;

  assign wr_we  = wr_data[WEB +: NCH];
  assign wr_val = wr_data[NCH-1:0];

  assign master_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_MASTER);
  assign chen_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_CHEN) && master_on;
  assign sreq_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_SREQ);
  assign dreq_wr   = wr_en && (reg_sel_e'(wr_sel) == SEL_DREQ);
  assign chen_we_eff = chen_wr ? wr_we : '0;

  dmaen_master u_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (master_wr),
    .wr_val   (wr_data[0]),
    .any_busy (|ch_busy),
    .on_q     (master_on),
    .on_next  (master_next),
    .drain_q  (master_drain),
    .shown    (master_shown)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmaen_en_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_next (master_next),
      .wr_hit      (chen_wr),
      .we          (wr_we[i]),
      .val         (wr_val[i]),
      .done        (ch_done[i]),
      .en          (ch_en[i])
    );
  end

  dmaen_req_bank #(.NCH(NCH)) u_sreq (
    .clk(clk), .rst_n(rst_n), .wr_hit(sreq_wr), .we(wr_we), .val(wr_val),
    .ch_en(ch_en), .sw_sel(src_sw_sel), .ack(src_ack), .req(src_req)
  );

  dmaen_req_bank #(.NCH(NCH)) u_dreq (
    .clk(clk), .rst_n(rst_n), .wr_hit(dreq_wr), .we(wr_we), .val(wr_val),
    .ch_en(ch_en), .sw_sel(dst_sw_sel), .ack(dst_ack), .req(dst_req)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_MASTER: rd_data = {{(NCH-1){1'b0}}, master_shown};
      SEL_CHEN:   rd_data = master_on ? ch_en : '0;
      SEL_SREQ:   rd_data = src_req;
      default:    rd_data = dst_req;
    endcase
  end
endmodule

// File: rtl/dmaen_ctrl_chk.sv
module dmaen_ctrl_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           master_on,
  input logic           master_shown,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ch_done,
  input logic [NCH-1:0] ch_busy,
  input logic [NCH-1:0] chen_we_eff,
  input logic [NCH-1:0] src_req,
  input logic [NCH-1:0] src_ack,
  input logic [NCH-1:0] dst_req
);
  // R3
  master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master_on |-> ch_en == '0);

  // R4
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_done != '0) |=> (ch_en & $past(ch_done)) == '0);

  // R6
  drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_shown) |-> $past(ch_busy) == '0);

  // R2
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    master_on |=> !master_on ||
      ((ch_en ^ $past(ch_en)) & ~$past(chen_we_eff) & ~$past(ch_done)) == '0);

  // R7
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_req & ~$past(src_req) & ~$past(ch_en)) == '0) &&
    ((dst_req & ~$past(dst_req) & ~$past(ch_en)) == '0));

  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_ack & src_req) != '0) |=> (src_req & $past(src_ack & src_req)) == '0);
endmodule

bind dmaen_ctrl dmaen_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_on(master_on), .master_shown(master_shown),
  .ch_en(ch_en), .ch_done(ch_done), .ch_busy(ch_busy), .chen_we_eff(chen_we_eff),
  .src_req(src_req), .src_ack(src_ack), .dst_req(dst_req)
);

// File: tb/dmaen_ctrl_test.sv
`timescale 1ns/1ps
module dmaen_ctrl_test;
  localparam int NCH = 8;
  localparam int NV  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [2*NCH-1:0] wr_data = '0;
  logic [1:0] rd_sel = '0;
  logic [NCH-1:0] rd_data;
  logic [NCH-1:0] ch_busy = '0, ch_done = '0;
  logic [NCH-1:0] src_sw_sel = '1, dst_sw_sel = '1;
  logic [NCH-1:0] src_ack = '0, dst_ack = '0;
  logic [NCH-1:0] ch_en, src_req, dst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmaen_ctrl #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .ch_busy(ch_busy), .ch_done(ch_done),
    .src_sw_sel(src_sw_sel), .dst_sw_sel(dst_sw_sel), .src_ack(src_ack),
    .dst_ack(dst_ack), .ch_en(ch_en), .src_req(src_req), .dst_req(dst_req)
  );

  // {write select, write data, read select, expected readback}
  localparam logic [27:0] VEC [NV] = '{
    {2'd1, 16'hFFA5, 2'd1, 8'hA5},   // R2 all enables
    {2'd1, 16'h0F0A, 2'd1, 8'hAA},   // R2 low nibble only
    {2'd1, 16'h00FF, 2'd1, 8'hAA},   // R2 no enables
    {2'd1, 16'h8100, 2'd1, 8'h2A},   // R2 sparse clear
    {2'd2, 16'hFFFF, 2'd2, 8'h2A},   // R7 only enabled channels
    {2'd3, 16'h0303, 2'd3, 8'h02},   // R7 ch0 disabled, ch1 enabled
    {2'd2, 16'h0200, 2'd2, 8'h28},   // R7 masked clear
    {2'd1, 16'h2000, 2'd2, 8'h08},   // R10 channel 5 disabled drops request
    {2'd0, 16'h0000, 2'd1, 8'h00},   // R3 master off reads 0
    {2'd1, 16'hFFFF, 2'd1, 8'h00},   // R3 write ignored while off
    {2'd0, 16'h0001, 2'd0, 8'h01},   // R6 master on reads 1
    {2'd1, 16'h0000, 2'd1, 8'h00}    // R3 bits stay cleared after re-enable
  };

  task automatic check(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [2*NCH-1:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic read_chk(input string tag, input logic [1:0] sel, input logic [NCH-1:0] exp);
    rd_sel = sel; #0.5;
    check(tag, rd_data, exp);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    // R1 reset state
    for (int s = 0; s < 4; s++) read_chk("R1 readback", s[1:0], 8'h00);
    check("R1 ch_en", ch_en, 8'h00);
    check("R1 src_req", src_req | dst_req, 8'h00);
    rst_n = 1'b1;
    idle(2);

    do_write(2'd0, 16'h0001);
    idle(1);
    for (int v = 0; v < NV; v++) begin
      do_write(VEC[v][27:26], VEC[v][25:10]);
      idle(2);
      read_chk($sformatf("vector %0d", v), VEC[v][9:8], VEC[v][7:0]);
    end

    // R5 done beats a same-cycle setting write
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h0404; ch_done = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; ch_done = '0;
    check("R5 done priority", ch_en, 8'h00);

    // R4 plain done clears only its bit
    do_write(2'd1, 16'h0909);
    @(negedge clk); ch_done = 8'h08;
    @(negedge clk); ch_done = '0;
    check("R4 done clears", ch_en, 8'h01);

    // R6 drain: channel 0 busy while master cleared
    ch_busy = 8'h01;
    do_write(2'd0, 16'h0000);
    check("R3 ch_en on master off", ch_en, 8'h00);
    read_chk("R6 master reads 1 while busy", 2'd0, 8'h01);
    idle(3);
    read_chk("R6 still draining", 2'd0, 8'h01);
    ch_busy = '0;
    @(negedge clk);
    read_chk("R6 drained", 2'd0, 8'h00);

    // R8 / R7 / R9 / R10 requests
    do_write(2'd0, 16'h0001);
    do_write(2'd1, 16'h0101);
    src_sw_sel = 8'hFE;
    do_write(2'd2, 16'h0101);
    check("R8 src req no sw handshake", src_req, 8'h00);
    read_chk("R8 src readback", 2'd2, 8'h00);
    do_write(2'd3, 16'h0101);
    check("R7 dst req enabled channel", dst_req, 8'h01);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 16'h0101; dst_ack = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; dst_ack = '0;
    check("R9 ack beats write", dst_req, 8'h00);
    do_write(2'd3, 16'h0101);
    do_write(2'd1, 16'h0100);
    idle(1);
    check("R10 disabled channel clears request", dst_req, 8'h00);
    do_write(2'd3, 16'h0101);
    check("R7 write to disabled channel", dst_req, 8'h00);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule